// File: doc/BRIEF.md
# Neighbourhood Scan Phase Sequencer

This controller is global to a pixel array that applies a rank-order filter while it digitises with a single-slope converter. For every ramp step it sends the array its strobes in a fixed order. A self-load strobe latches each pixel's comparator into its shift cell. A rank-load strobe loads the rank counters. A walk over the neighbourhood follows, made of count pulses and one-hot north/east/south/west shift strobes. An evaluation strobe then lets each pixel freeze its conversion counter once its rank is reached. After each evaluation the sequencer advances the ramp-step index. After the last step it pulses frame done.

The walk is a spiral that starts at the centre and turns outward through north, east, south and west. The 3×3 and 5×5 masks share its first nine slots. A cross-shaped mask uses the 3×3 path, and at the corner positions it passes through it holds back the count pulse. The mask shape is latched when a frame starts. The rank value is sampled once per ramp step. Changing the rank mid-frame therefore takes effect at a step boundary, so one frame can run, for example, a minimum filter for its first half and a maximum filter for its second half.

States: IDLE waits for start. SELF issues the self-load strobe. LOAD issues the rank-load strobe. WALK covers one slot per cycle. EVAL issues the evaluation strobe. DONE issues the frame-done pulse. Transitions: IDLE→SELF on start. SELF→LOAD always. LOAD→WALK always, at slot 0. WALK→WALK while slots remain. WALK→EVAL after the final slot. EVAL→SELF when more steps remain. EVAL→DONE after the last step. DONE→IDLE always.

Top module: `neighbourhood_scan_seq`

## Requirements
- R1: While reset is held and until the first start, every strobe output is low, `step_idx` is 0 and `rank_out` is 0.
- R2: A start seen in IDLE gives, in the next cycle, a self-load strobe alone. Then comes one cycle of rank-load. Then comes a count pulse for the centre slot (slot 0) with no shift strobe.
- R3: With `mask_sel` = 0 (3×3) the walk has 9 slots. Slots 1 to 8 shift N, E, S, S, W, W, N, N. Every slot carries a count pulse. One evaluation cycle follows, so a ramp step lasts 12 cycles.
- R4: With `mask_sel` = 1 (5×5) the walk has 25 slots. The first 9 match R3. Slots 9 to 24 shift N, E, E, E, S, S, S, S, W, W, W, W, N, N, N, N. Every slot counts, so a step lasts 28 cycles.
- R5: With `mask_sel` = 2 (cross) the shifts follow R3, but count pulses appear only in slots 0, 1, 3, 5 and 7. `mask_sel` = 3 behaves as 3×3.
- R6: `shift_stb` uses bit 0 = N, bit 1 = E, bit 2 = S and bit 3 = W. At most one bit is high at a time. A shift strobe appears only in walk slots 1 and up, in the same cycle as that slot's count decision.
- R7: `step_idx` holds the current ramp step from its self-load cycle through its evaluation cycle. It advances by one after each evaluation. A frame has `STEPS` steps, and the index returns to 0 after the last.
- R8: `rank_out` takes the `rank_in` value present in the self-load cycle. It shows that value from the rank-load cycle on and holds it until the next rank-load, so a change takes effect from the next ramp step.
- R9: `frame_done` is high for exactly one cycle, the cycle after the evaluation of step `STEPS`-1. The sequencer then returns to IDLE.
- R10: A start asserted during a frame, including its frame-done cycle, is ignored. So is any change of `mask_sel` during a frame.
- R11: Self-load, rank-load, count, evaluation and frame-done are mutually exclusive in every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sequencer clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a frame (honoured in IDLE only) |
| mask_sel | input | 2 | Mask shape: 0 3×3, 1 5×5, 2 cross, 3 as 3×3 |
| rank_in | input | RANK_W | Rank to load into the pixels |
| self_stb | output | 1 | Latch comparator into the shift cell |
| rank_ld | output | 1 | Load pixel rank counters from `rank_out` |
| count_stb | output | 1 | Count the cell now at the centre |
| shift_stb | output | 4 | One-hot shift strobe {W,S,E,N} |
| eval_stb | output | 1 | Evaluate rank counters |
| step_idx | output | STEP_W | Current ramp-step index |
| rank_out | output | RANK_W | Rank on the load bus for this step |
| frame_done | output | 1 | One-cycle end-of-frame pulse |

## Verification
The bench keeps the default of 512 ramp steps and a 5-bit rank. Full-length frames therefore show the index wrapping, a mid-frame rank switch at step 256 from 1 to 9, and the frame-done timing after step 511, in 3×3, 5×5 (rank 25), cross and reserved-code modes. With start held high across a frame end, the frame-done cycle must ignore it and the following idle cycle must accept it. A start pulse and a mask change injected mid-frame must leave the frame length untouched.

// File: rtl/nscan_pkg.sv
package nscan_pkg;

    typedef enum logic [2:0] {
        ST_IDLE, ST_SELF, ST_LOAD, ST_WALK, ST_EVAL, ST_DONE
    } seq_state_t;

    typedef enum logic [1:0] {
        MASK_SQ3 = 2'd0, MASK_SQ5 = 2'd1, MASK_CROSS = 2'd2, MASK_RSVD = 2'd3
    } mask_t;

    typedef enum logic [1:0] { DIR_N, DIR_E, DIR_S, DIR_W } dir_t;

    localparam int SLOTS_SQ3 = 9;
    localparam int SLOTS_SQ5 = 25;
    localparam int SLOT_W    = $clog2(SLOTS_SQ5);
    localparam int SPIRAL_SEGS = 10;

    // Outward spiral: segment s has length s/2+1 and heading s mod 4 (N,E,S,W).
    function automatic dir_t spiral_dir(input logic [SLOT_W-1:0] k);
        int   acc;
        int   len;
        dir_t d;
        acc = 1;
        d   = DIR_N;
        for (int s = 0; s < SPIRAL_SEGS; s++) begin
            len = s / 2 + 1;
            if (int'(k) >= acc && int'(k) < acc + len)
                d = dir_t'(s[1:0]);
            acc = acc + len;
        end
        return d;
    endfunction

endpackage

// File: rtl/nscan_walk_decode.sv
module nscan_walk_decode
    import nscan_pkg::*;
(
    input  logic              in_walk,
    input  logic [SLOT_W-1:0] slot,
    input  mask_t             mask,
    output logic [3:0]        shift_oh,
    output logic              count_en,
    output logic              last_slot
);

    logic is_big;
    assign is_big = (mask == MASK_SQ5);

    always_comb begin
        last_slot = is_big ? (slot == SLOT_W'(SLOTS_SQ5 - 1))
                           : (slot == SLOT_W'(SLOTS_SQ3 - 1));
        // Cross: corner positions of the 3x3 path sit on even slots above zero
        if (mask == MASK_CROSS)
            count_en = in_walk && (slot == '0 || slot[0]);
        else
            count_en = in_walk;
        shift_oh = '0;
        if (in_walk && slot != '0)
            shift_oh = 4'b0001 << spiral_dir(slot);
    end

endmodule

// File: rtl/nscan_step_ctr.sv
module nscan_step_ctr #(
    parameter int STEPS  = 512,
    parameter int STEP_W = $clog2(STEPS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              advance,
    output logic [STEP_W-1:0] step_q,
    output logic              last_step
);

    assign last_step = (step_q == STEP_W'(STEPS - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            step_q <= '0;
        else if (advance)
            step_q <= last_step ? '0 : step_q + 1'b1;
    end

endmodule

// File: rtl/nscan_fsm.sv
module nscan_fsm
    import nscan_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              last_slot,
    input  logic              last_step,
    output seq_state_t        state,
    output logic [SLOT_W-1:0] slot
);

    seq_state_t nxt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            slot  <= '0;
        end else begin
            state <= nxt;
            if (state == ST_LOAD)
                slot <= '0;
            else if (state == ST_WALK)
                slot <= slot + 1'b1;
        end
    end

    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE: if (start) nxt = ST_SELF;
            ST_SELF: nxt = ST_LOAD;
            ST_LOAD: nxt = ST_WALK;
            ST_WALK: if (last_slot) nxt = ST_EVAL;
            ST_EVAL: nxt = last_step ? ST_DONE : ST_SELF;
            ST_DONE: nxt = ST_IDLE;
            default: nxt = ST_IDLE;
        endcase
    end

endmodule

// File: rtl/neighbourhood_scan_seq.sv
module neighbourhood_scan_seq
    import nscan_pkg::*;
#(
    parameter int STEPS  = 512,
    parameter int RANK_W = 5,
    localparam int STEP_W = $clog2(STEPS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [1:0]        mask_sel,
    input  logic [RANK_W-1:0] rank_in,
    output logic              self_stb,
    output logic              rank_ld,
    output logic              count_stb,
    output logic [3:0]        shift_stb,
    output logic              eval_stb,
    output logic [STEP_W-1:0] step_idx,
    output logic [RANK_W-1:0] rank_out,
    output logic              frame_done
);

    seq_state_t        state;
    logic [SLOT_W-1:0] slot;
    logic              last_slot;
    logic              last_step;
    logic              count_en;
    logic [3:0]        shift_oh;
    mask_t             mask_q;
    logic [RANK_W-1:0] rank_q;

    nscan_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .last_slot (last_slot),
        .last_step (last_step),
        .state     (state),
        .slot      (slot)
    );

    nscan_walk_decode u_walk (
        .in_walk   (state == ST_WALK),
        .slot      (slot),
        .mask      (mask_q),
        .shift_oh  (shift_oh),
        .count_en  (count_en),
        .last_slot (last_slot)
    );

    nscan_step_ctr #(.STEPS(STEPS), .STEP_W(STEP_W)) u_step (
        .clk       (clk),
        .rst_n     (rst_n),
        .advance   (state == ST_EVAL),
        .step_q    (step_idx),
        .last_step (last_step)
    );

    // Mask shape fixed per frame; rank captured at the edge entering rank-load
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mask_q <= MASK_SQ3;
            rank_q <= '0;
        end else begin
            if (state == ST_IDLE && start)
                mask_q <= mask_t'(mask_sel);
            if (state == ST_SELF)
                rank_q <= rank_in;
        end
    end

    assign rank_out = rank_q;

    always_comb begin
        self_stb   = 1'b0;
        rank_ld    = 1'b0;
        count_stb  = 1'b0;
        shift_stb  = '0;
        eval_stb   = 1'b0;
        frame_done = 1'b0;
        unique case (state)
            ST_IDLE: ;
            ST_SELF: self_stb = 1'b1;
            ST_LOAD: rank_ld  = 1'b1;
            ST_WALK: begin
                count_stb = count_en;
                shift_stb = shift_oh;
            end
            ST_EVAL: eval_stb   = 1'b1;
            ST_DONE: frame_done = 1'b1;
            default: ;
        endcase
    end

endmodule

// File: rtl/nscan_checker.sv
module nscan_checker #(
    parameter int STEPS  = 512,
    parameter int RANK_W = 5,
    parameter int STEP_W = $clog2(STEPS)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              self_stb,
    input logic              rank_ld,
    input logic              count_stb,
    input logic [3:0]        shift_stb,
    input logic              eval_stb,
    input logic [STEP_W-1:0] step_idx,
    input logic [RANK_W-1:0] rank_out,
    input logic              frame_done
);

    AST_SELF_THEN_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        self_stb |=> rank_ld && !self_stb); // R2

    AST_LOAD_THEN_CENTRE: assert property (@(posedge clk) disable iff (!rst_n)
        rank_ld |=> count_stb && shift_stb == 4'b0000); // R2

    AST_SHIFT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(shift_stb)); // R6

    AST_STROBES_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({self_stb, rank_ld, count_stb, eval_stb, frame_done}) <= 1); // R11

    AST_RANK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !rank_ld |-> $stable(rank_out)); // R8

    AST_STEP_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
        eval_stb && step_idx != STEP_W'(STEPS - 1) |=> step_idx == $past(step_idx) + 1'b1); // R7

    AST_LAST_EVAL_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        eval_stb && step_idx == STEP_W'(STEPS - 1) |=> frame_done); // R9

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done |=> !frame_done && !self_stb && step_idx == '0); // R9

endmodule

bind neighbourhood_scan_seq nscan_checker #(.STEPS(STEPS), .RANK_W(RANK_W), .STEP_W(STEP_W)) u_nscan_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .self_stb   (self_stb),
    .rank_ld    (rank_ld),
    .count_stb  (count_stb),
    .shift_stb  (shift_stb),
    .eval_stb   (eval_stb),
    .step_idx   (step_idx),
    .rank_out   (rank_out),
    .frame_done (frame_done)
);

// File: tb/neighbourhood_scan_seq_bench.sv
module neighbourhood_scan_seq_bench;

    localparam int STEPS  = 512;
    localparam int RANK_W = 5;
    localparam int STEP_W = $clog2(STEPS);

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              start = 1'b0;
    logic [1:0]        mask_sel = 2'd0;
    logic [RANK_W-1:0] rank_in = '0;
    logic              self_stb, rank_ld, count_stb, eval_stb, frame_done;
    logic [3:0]        shift_stb;
    logic [STEP_W-1:0] step_idx;
    logic [RANK_W-1:0] rank_out;

    always #2.5 clk = ~clk;

    neighbourhood_scan_seq #(.STEPS(STEPS), .RANK_W(RANK_W)) u_neighbourhood_scan_seq (
        .clk(clk), .rst_n(rst_n), .start(start), .mask_sel(mask_sel), .rank_in(rank_in),
        .self_stb(self_stb), .rank_ld(rank_ld), .count_stb(count_stb), .shift_stb(shift_stb),
        .eval_stb(eval_stb), .step_idx(step_idx), .rank_out(rank_out), .frame_done(frame_done)
    );

    typedef struct packed {
        logic        self_e, ld_e, cnt_e;
        logic [3:0]  sh_e;
        logic        ev_e, dn_e;
        logic [15:0] step_e;
    } cyc_t;

    int   n_cmp = 0;
    int   n_bad = 0;
    int   cycles = 0;
    cyc_t q[$];
    cyc_t cur = '0;
    int   mrank = 0;
    int   mmode = 0;
    // Spiral headings per slot (index 0 unused): 0=N 1=E 2=S 3=W
    int   heading[25] = '{0, 0,1,2,2,3,3,0,0, 0,1,1,1,2,2,2,2,3,3,3,3,0,0,0,0};

    task automatic chk(input string tag, input int act, input int exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s at cycle %0d: actual %0d expected %0d", tag, cycles, act, exp);
        end
    endtask

    task automatic build_frame(input int mode);
        int   nslots;
        cyc_t e;
        nslots = (mode == 1) ? 25 : 9;
        for (int s = 0; s < STEPS; s++) begin
            e = '0; e.step_e = 16'(s); e.self_e = 1'b1; q.push_back(e);
            e = '0; e.step_e = 16'(s); e.ld_e = 1'b1;   q.push_back(e);
            for (int k = 0; k < nslots; k++) begin
                e = '0; e.step_e = 16'(s);
                e.cnt_e = (mode != 2) || (k == 0) || (k % 2 == 1);
                if (k > 0) e.sh_e = 4'b0001 << heading[k];
                q.push_back(e);
            end
            e = '0; e.step_e = 16'(s); e.ev_e = 1'b1; q.push_back(e);
        end
        e = '0; e.dn_e = 1'b1; q.push_back(e);
    endtask

    // Behavioural model: advances one entry per clock
    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.delete(); cur = '0; mrank = 0; mmode = 0;
        end else if (q.size() > 0) begin
            cur = q.pop_front();
            if (cur.ld_e) mrank = int'(rank_in);
        end else if (cur == '0 && start) begin
            mmode = int'(mask_sel);
            build_frame(mmode);
            cur = q.pop_front();
        end else begin
            cur = '0;
        end
    end

    always @(negedge clk) begin
        cycles++;
        if (rst_n) begin
            string ct;
            ct = (mmode == 1) ? "R4" : (mmode == 2) ? "R5" : "R3";
            chk("R2 self_stb", self_stb, cur.self_e);
            chk("R2 rank_ld", rank_ld, cur.ld_e);
            chk({ct, " count_stb"}, count_stb, cur.cnt_e);
            chk("R6 shift_stb", shift_stb, cur.sh_e);
            chk("R3 eval_stb", eval_stb, cur.ev_e);
            chk("R9 frame_done", frame_done, cur.dn_e);
            chk("R7 step_idx", step_idx, cur.step_e);
            chk("R8 rank_out", rank_out, mrank);
            chk("R11 exclusive", $countones({self_stb, rank_ld, count_stb, eval_stb, frame_done}) <= 1, 1);
        end
    end

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        forever begin
            @(negedge clk);
            if (cycles > 190000) begin
                n_bad++;
                $display("FAIL watchdog expired at cycle %0d: actual hung expected done", cycles);
                finish_run();
            end
        end
    end

    // Runs one frame; returns cycles from start to the frame-done pulse
    task automatic run_frame(input int mode, input int rank, input bit disturb, output int len);
        @(negedge clk);
        mask_sel = 2'(mode); rank_in = RANK_W'(rank); start = 1'b1;
        len = 0;
        @(negedge clk); start = 1'b0; len = 1;
        while (!frame_done) begin
            if (disturb && step_idx == STEP_W'(STEPS / 2) && self_stb) begin
                rank_in = RANK_W'(9); start = 1'b1; mask_sel = 2'd1;
            end else if (disturb) begin
                start = 1'b0;
            end
            @(negedge clk); len++;
        end
        start = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    initial begin
        int len;
        repeat (3) @(negedge clk);
        chk("R1 reset strobes", {self_stb, rank_ld, count_stb, shift_stb, eval_stb, frame_done}, 0);
        chk("R1 reset step", step_idx, 0);
        chk("R1 reset rank", rank_out, 0);
        rank_in = 5'd7;
        @(negedge clk); rst_n = 1'b1;
        repeat (4) @(negedge clk);
        chk("R1 idle strobes", {self_stb, rank_ld, count_stb, shift_stb, eval_stb, frame_done}, 0);
        chk("R1 idle rank", rank_out, 0);

        // 3x3, rank 1 switched to 9 mid-frame, with stray start and mask change
        run_frame(0, 1, 1'b1, len);
        chk("R10 frame length unchanged", len, STEPS * 12 + 1);
        chk("R8 rank after switch", rank_out, 9);
        run_frame(1, 25, 1'b0, len);
        chk("R4 5x5 frame length", len, STEPS * 28 + 1);
        run_frame(2, 3, 1'b0, len);
        chk("R5 cross frame length", len, STEPS * 12 + 1);

        // Reserved code, start held across the frame end
        @(negedge clk);
        mask_sel = 2'd3; rank_in = 5'd5; start = 1'b1;
        while (!frame_done) @(negedge clk);
        @(negedge clk);
        chk("R10 start ignored in done cycle", self_stb, 0);
        @(negedge clk);
        chk("R9 restart from idle", self_stb, 1);
        start = 1'b0;
        while (!frame_done) @(negedge clk);
        repeat (3) @(negedge clk);
        chk("R7 index back to zero", step_idx, 0);
        finish_run();
    end

endmodule